// File: doc/BRIEF.md
# Four-Way Translation Lookaside Buffer with Explicit Load

This block translates 32-bit virtual addresses into physical addresses. It holds four ways of 32 sets each. Every entry keeps an address half and a data half. The address half holds the upper virtual page bits, an 8-bit address-space identifier (ASID) and a valid flag. The data half holds the physical page number, a two-bit protection code and flags for page size, cacheable, dirty and shared. An entry maps either a 1-kbyte or a 4-kbyte page, so the set of tag bits compared can differ from one entry to the next.

Software fills the buffer directly; there is no replacement policy. It first writes a staged high word (virtual page and current ASID) and a staged low word (physical page and flags), then issues a load strobe. The load copies both words into the way named by a replacement-counter field of the control register. The set is chosen from virtual page bits 16:12. When the index-hash control is set, those bits are XORed with the low ASID bits. The staged ASID also serves as the current ASID for every lookup.

A lookup port takes a virtual address, a privilege flag and a write flag. One cycle later it reports one of the following: a hit with its physical address, a miss, a hit in more than one way, a protection violation, or a first write to a clean page. When translation is disabled, the address passes through unchanged.

Top module: `tlb4w`

## Requirements
- R1: After reset every entry is invalid, all control fields are 0, and all outputs are 0. Translation is therefore off, and a lookup returns its own address as the physical address.
- R2: A load strobe writes the staged words into way `rc` at set `hi[16:12] ^ (ix ? hi[4:0] : 0)`, using the control and staged values held before that edge. The valid flag is taken from `lo[0]`. A lookup issued in the cycle after the load can hit the new entry.
- R3: `rsp_valid_o` is 1 exactly one cycle after a cycle with `lk_req_i` = 1. When there was no request, every result output is 0.
- R4: An entry with `lo[1]` = 1 is a 4-kbyte page. It matches on virtual bits 31:17 and ignores bits 11:10. Its physical address is {3'b0, PPN[28:12], va[11:0]}, and `cache_o` gives its cacheable flag `lo[2]`.
- R5: An entry with `lo[1]` = 0 is a 1-kbyte page. It also compares virtual bits 11:10. Its physical address is {3'b0, PPN[28:10], va[9:0]}.
- R6: The entry ASID `hi[7:0]` must equal the current ASID. This check is skipped when the entry shared flag `lo[4]` is 1, or when `sv` is 1 and `lk_priv_i` is 1.
- R7: With translation on, if no valid entry of the indexed set matches, `miss_o` is 1 and `pa_o` is 0.
- R8: If more than one way matches, `multi_o` is 1 and both `hit_o` and `miss_o` are 0.
- R9: The protection code is `lo[6:5]`: 00 privileged read, 01 privileged read/write, 10 read for both modes, 11 read/write for both. `prot_o` is 1 on a hit in either of two cases: a user access (`lk_priv_i` = 0) when `lo[6]` = 0, or a write when `lo[5]` = 0.
- R10: `dfault_o` is 1 on a hit with no protection violation, a write, and dirty flag `lo[3]` = 0.
- R11: A control write with `ctrl_tf_i` = 1 clears every valid flag at that edge. A load in the same edge still installs its own entry.
- R12: With `at` = 0, a lookup returns `pa_o` = va and 0 on every flag output.
- R13: With `ix` = 1, lookups and loads index the set as `va[16:12] ^ asid[4:0]`, so an entry loaded with `ix` = 0 is no longer found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_at_i | input | 1 | Translation enable value |
| ctrl_ix_i | input | 1 | Index-hash enable value |
| ctrl_sv_i | input | 1 | Privileged ASID-ignore value |
| ctrl_tf_i | input | 1 | Flush request (not stored) |
| ctrl_rc_i | input | 2 | Way to be written by loads |
| hi_we_i | input | 1 | Staged high word write strobe |
| hi_i | input | 32 | VPN at [31:10], ASID at [7:0] |
| lo_we_i | input | 1 | Staged low word write strobe |
| lo_i | input | 32 | PPN [28:10], PR [6:5], SH [4], D [3], C [2], SZ [1], V [0] |
| load_i | input | 1 | Copy staged words into the buffer |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_priv_i | input | 1 | Lookup is privileged |
| lk_write_i | input | 1 | Lookup is a write |
| rsp_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Single-way hit |
| miss_o | output | 1 | No matching entry |
| multi_o | output | 1 | More than one way matched |
| prot_o | output | 1 | Protection violation |
| dfault_o | output | 1 | Write to a clean page |
| cache_o | output | 1 | Hit page is cacheable |
| pa_o | output | 32 | Physical address |

## Verification
Every lookup result appears one clock edge after its request, because the result stage is the only register on that path. Control writes, staged-word writes and loads change state at their own edge, so they first affect a lookup issued in the following cycle. A lookup in the same cycle as a load still sees the old contents. The bench model applies this rule by first evaluating the lookup against its state from before the edge, and only then updating that state. It compares every output 2 ns after each rising edge. The directed checks sample 3 ns after the edge that follows their request.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned ASID_W = 8;
  localparam int unsigned PPN_W  = 19;

  typedef struct packed {
    logic [14:0]       vpn_hi;  // va[31:17]
    logic [1:0]        vpn_lo;  // va[11:10]
    logic [ASID_W-1:0] asid;
  } tag_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;      // pa[28:10]
    logic [1:0]       pr;
    logic             sz;       // 1: 4 kbyte
    logic             c;
    logic             d;
    logic             sh;
  } pdata_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int unsigned WAY_W    = 2,
  parameter int unsigned SET_BITS = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ctrl_we_i,
  input  logic                ctrl_at_i,
  input  logic                ctrl_ix_i,
  input  logic                ctrl_sv_i,
  input  logic                ctrl_tf_i,
  input  logic [WAY_W-1:0]    ctrl_rc_i,
  input  logic                hi_we_i,
  input  logic [VA_W-1:0]     hi_i,
  input  logic                lo_we_i,
  input  logic [VA_W-1:0]     lo_i,
  output logic                at_o,
  output logic                ix_o,
  output logic                sv_o,
  output logic [WAY_W-1:0]    rc_o,
  output logic                flush_o,
  output tag_t                tag_o,
  output pdata_t              data_o,
  output logic                v_o,
  output logic [ASID_W-1:0]   asid_o,
  output logic [SET_BITS-1:0] wr_idx_o
);
  logic [21:0]       vpn_q;
  logic [ASID_W-1:0] asid_q;
  pdata_t            data_q;
  logic              v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      at_o <= 1'b0;
      ix_o <= 1'b0;
      sv_o <= 1'b0;
      rc_o <= '0;
    end else if (ctrl_we_i) begin
      at_o <= ctrl_at_i;
      ix_o <= ctrl_ix_i;
      sv_o <= ctrl_sv_i;
      rc_o <= ctrl_rc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpn_q  <= '0;
      asid_q <= '0;
    end else if (hi_we_i) begin
      vpn_q  <= hi_i[31:10];
      asid_q <= hi_i[ASID_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      v_q    <= 1'b0;
    end else if (lo_we_i) begin
      data_q <= '{ppn: lo_i[28:10], pr: lo_i[6:5], sh: lo_i[4], d: lo_i[3],
                  c: lo_i[2], sz: lo_i[1]};
      v_q    <= lo_i[0];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{hi_i[9:ASID_W], lo_i[31:29], lo_i[9:7]};

  assign flush_o  = ctrl_we_i & ctrl_tf_i;
  assign tag_o    = '{vpn_hi: vpn_q[21:7], vpn_lo: vpn_q[1:0], asid: asid_q};
  assign data_o   = data_q;
  assign v_o      = v_q;
  assign asid_o   = asid_q;
  assign wr_idx_o = vpn_q[2 +: SET_BITS] ^ (ix_o ? asid_q[SET_BITS-1:0] : '0);
endmodule

// File: rtl/tlb_way.sv
module tlb_way
  import tlb_pkg::*;
#(
  parameter int unsigned SET_BITS = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                flush_i,
  input  logic [SET_BITS-1:0] wr_idx_i,
  input  tag_t                wr_tag_i,
  input  pdata_t              wr_data_i,
  input  logic                wr_v_i,
  input  logic [SET_BITS-1:0] rd_idx_i,
  input  logic [21:0]         va_tag_i,  // va[31:10]
  input  logic [ASID_W-1:0]   cur_asid_i,
  input  logic                asid_skip_i,
  output logic                hit_o,
  output pdata_t              rd_data_o
);
  localparam int unsigned SETS = 1 << SET_BITS;

  logic [SETS-1:0] valid_q;
  tag_t            tag_q  [SETS];
  pdata_t          data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (flush_i) valid_q <= '0;
      if (we_i)    valid_q[wr_idx_i] <= wr_v_i;  // load overrides flush
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  tag_t rd_tag;
  logic vpn_ok, asid_ok;
  logic unused_va;

  assign rd_tag    = tag_q[rd_idx_i];
  assign rd_data_o = data_q[rd_idx_i];
  assign vpn_ok    = (rd_tag.vpn_hi == va_tag_i[21:7]) &&
                     (rd_data_o.sz || rd_tag.vpn_lo == va_tag_i[1:0]);
  assign asid_ok   = rd_data_o.sh || asid_skip_i || (rd_tag.asid == cur_asid_i);
  assign hit_o     = valid_q[rd_idx_i] && vpn_ok && asid_ok;
  assign unused_va = ^va_tag_i[6:2];

  // R11
  a_r11_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !we_i) |=> (valid_q == '0));
  // R2
  a_r2_load_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (valid_q[$past(wr_idx_i)] == $past(wr_v_i)));
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [VA_W-1:0]     va_i,
  input  logic                priv_i,
  input  logic                write_i,
  input  logic                at_i,
  input  logic [NUM_WAYS-1:0] hit_vec_i,
  input  pdata_t              way_data_i [NUM_WAYS],
  output logic                rsp_valid_o,
  output logic                hit_o,
  output logic                miss_o,
  output logic                multi_o,
  output logic                prot_o,
  output logic                dfault_o,
  output logic                cache_o,
  output logic [VA_W-1:0]     pa_o
);
  pdata_t          sel;
  logic            one_hit, none_hit, viol;
  logic [VA_W-1:0] pa_tr;

  always_comb begin
    sel = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (hit_vec_i[w]) sel = sel | way_data_i[w];
    end
  end

  assign none_hit = (hit_vec_i == '0);
  assign one_hit  = ($countones(hit_vec_i) == 1);
  assign viol     = (!priv_i && !sel.pr[1]) || (write_i && !sel.pr[0]);
  assign pa_tr    = sel.sz ? {3'b000, sel.ppn[PPN_W-1:2], va_i[11:0]}
                           : {3'b000, sel.ppn, va_i[9:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      multi_o     <= 1'b0;
      prot_o      <= 1'b0;
      dfault_o    <= 1'b0;
      cache_o     <= 1'b0;
      pa_o        <= '0;
    end else begin
      rsp_valid_o <= req_i;
      hit_o       <= req_i && at_i && one_hit;
      miss_o      <= req_i && at_i && none_hit;
      multi_o     <= req_i && at_i && !none_hit && !one_hit;
      prot_o      <= req_i && at_i && one_hit && viol;
      dfault_o    <= req_i && at_i && one_hit && !viol && write_i && !sel.d;
      cache_o     <= req_i && at_i && one_hit && sel.c;
      pa_o        <= !req_i ? '0 : !at_i ? va_i : one_hit ? pa_tr : '0;
    end
  end

  // R8
  a_r8_multi_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_o |-> (!hit_o && !miss_o && rsp_valid_o));
  // R10
  a_r10_fault_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dfault_o |-> (hit_o && !prot_o && $past(write_i)));
endmodule

// File: rtl/tlb4w.sv
module tlb4w
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned SET_BITS = 5,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             ctrl_at_i,
  input  logic             ctrl_ix_i,
  input  logic             ctrl_sv_i,
  input  logic             ctrl_tf_i,
  input  logic [WAY_W-1:0] ctrl_rc_i,
  input  logic             hi_we_i,
  input  logic [31:0]      hi_i,
  input  logic             lo_we_i,
  input  logic [31:0]      lo_i,
  input  logic             load_i,
  input  logic             lk_req_i,
  input  logic [31:0]      lk_va_i,
  input  logic             lk_priv_i,
  input  logic             lk_write_i,
  output logic             rsp_valid_o,
  output logic             hit_o,
  output logic             miss_o,
  output logic             multi_o,
  output logic             prot_o,
  output logic             dfault_o,
  output logic             cache_o,
  output logic [31:0]      pa_o
);
  logic                at, ix, sv, flush, stg_v;
  logic [WAY_W-1:0]    rc;
  tag_t                stg_tag;
  pdata_t              stg_data;
  logic [ASID_W-1:0]   cur_asid;
  logic [SET_BITS-1:0] wr_idx, rd_idx;
  logic [NUM_WAYS-1:0] hit_vec;
  pdata_t              way_data [NUM_WAYS];

  tlb_ctrl #(.WAY_W(WAY_W), .SET_BITS(SET_BITS)) i_ctrl (
    .clk_i, .rst_ni,
    .ctrl_we_i, .ctrl_at_i, .ctrl_ix_i, .ctrl_sv_i, .ctrl_tf_i, .ctrl_rc_i,
    .hi_we_i, .hi_i, .lo_we_i, .lo_i,
    .at_o(at), .ix_o(ix), .sv_o(sv), .rc_o(rc), .flush_o(flush),
    .tag_o(stg_tag), .data_o(stg_data), .v_o(stg_v), .asid_o(cur_asid),
    .wr_idx_o(wr_idx)
  );

  assign rd_idx = lk_va_i[12 +: SET_BITS] ^ (ix ? cur_asid[SET_BITS-1:0] : '0);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_way #(.SET_BITS(SET_BITS)) i_way (
      .clk_i, .rst_ni,
      .we_i       (load_i && (rc == WAY_W'(w))),
      .flush_i    (flush),
      .wr_idx_i   (wr_idx),
      .wr_tag_i   (stg_tag),
      .wr_data_i  (stg_data),
      .wr_v_i     (stg_v),
      .rd_idx_i   (rd_idx),
      .va_tag_i   (lk_va_i[31:10]),
      .cur_asid_i (cur_asid),
      .asid_skip_i(sv && lk_priv_i),
      .hit_o      (hit_vec[w]),
      .rd_data_o  (way_data[w])
    );
  end

  tlb_resolve #(.NUM_WAYS(NUM_WAYS)) i_resolve (
    .clk_i, .rst_ni,
    .req_i(lk_req_i), .va_i(lk_va_i), .priv_i(lk_priv_i), .write_i(lk_write_i),
    .at_i(at), .hit_vec_i(hit_vec), .way_data_i(way_data),
    .rsp_valid_o, .hit_o, .miss_o, .multi_o, .prot_o, .dfault_o, .cache_o, .pa_o
  );

  // R3
  a_r3_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> rsp_valid_o);
  a_r3_quiet_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> (!rsp_valid_o && !hit_o && !miss_o && pa_o == '0));
  // R12
  a_r12_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_req_i && !at) |=> (pa_o == $past(lk_va_i) && !hit_o && !miss_o && !multi_o));
endmodule

// File: tb/test_tlb4w.sv
module test_tlb4w;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctrl_we = 0, ctrl_at = 0, ctrl_ix = 0, ctrl_sv = 0, ctrl_tf = 0;
  logic [1:0]  ctrl_rc = 0;
  logic        hi_we = 0, lo_we = 0, load = 0;
  logic [31:0] hi = 0, lo = 0;
  logic        lk_req = 0, lk_priv = 0, lk_write = 0;
  logic [31:0] lk_va = 0;
  logic        rsp_valid, hit, miss, multi, prot, dfault, cache;
  logic [31:0] pa;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tlb4w i_tlb4w (
    .clk_i(clk), .rst_ni,
    .ctrl_we_i(ctrl_we), .ctrl_at_i(ctrl_at), .ctrl_ix_i(ctrl_ix),
    .ctrl_sv_i(ctrl_sv), .ctrl_tf_i(ctrl_tf), .ctrl_rc_i(ctrl_rc),
    .hi_we_i(hi_we), .hi_i(hi), .lo_we_i(lo_we), .lo_i(lo), .load_i(load),
    .lk_req_i(lk_req), .lk_va_i(lk_va), .lk_priv_i(lk_priv), .lk_write_i(lk_write),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .miss_o(miss), .multi_o(multi),
    .prot_o(prot), .dfault_o(dfault), .cache_o(cache), .pa_o(pa)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit          m_v   [4][32];
  logic [31:0] m_ehi [4][32];
  logic [31:0] m_elo [4][32];
  logic [31:0] m_hi, m_lo;
  logic        m_at, m_ix, m_sv;
  logic [1:0]  m_rc;
  logic        e_rv, e_hit, e_miss, e_multi, e_prot, e_df, e_c;
  logic [31:0] e_pa;

  always @(posedge clk) begin
    int          n, hw;
    logic [4:0]  idx;
    logic [31:0] eh, el;
    e_rv = 0; e_hit = 0; e_miss = 0; e_multi = 0; e_prot = 0; e_df = 0; e_c = 0; e_pa = 0;
    if (!rst_ni) begin
      for (int w = 0; w < 4; w++) for (int s = 0; s < 32; s++) m_v[w][s] = 0;
      m_hi = 0; m_lo = 0; m_at = 0; m_ix = 0; m_sv = 0; m_rc = 0;
    end else begin
      if (lk_req) begin
        e_rv = 1;
        if (!m_at) e_pa = lk_va;
        else begin
          idx = lk_va[16:12] ^ (m_ix ? m_hi[4:0] : 5'd0);
          n = 0; hw = 0;
          for (int w = 0; w < 4; w++) begin
            eh = m_ehi[w][idx]; el = m_elo[w][idx];
            if (m_v[w][idx] && eh[31:17] == lk_va[31:17] &&
                (el[1] || eh[11:10] == lk_va[11:10]) &&
                (el[4] || (m_sv && lk_priv) || eh[7:0] == m_hi[7:0])) begin
              n++; hw = w;
            end
          end
          if (n == 0) e_miss = 1;
          else if (n > 1) e_multi = 1;
          else begin
            el = m_elo[hw][idx];
            e_hit  = 1;
            e_prot = (!lk_priv && !el[6]) || (lk_write && !el[5]);
            e_df   = !e_prot && lk_write && !el[3];
            e_c    = el[2];
            e_pa   = el[1] ? {3'b0, el[28:12], lk_va[11:0]} : {3'b0, el[28:10], lk_va[9:0]};
          end
        end
      end
      if (ctrl_we && ctrl_tf)
        for (int w = 0; w < 4; w++) for (int s = 0; s < 32; s++) m_v[w][s] = 0;
      if (load) begin
        idx = m_hi[16:12] ^ (m_ix ? m_hi[4:0] : 5'd0);
        m_v[m_rc][idx] = m_lo[0]; m_ehi[m_rc][idx] = m_hi; m_elo[m_rc][idx] = m_lo;
      end
      if (ctrl_we) begin m_at = ctrl_at; m_ix = ctrl_ix; m_sv = ctrl_sv; m_rc = ctrl_rc; end
      if (hi_we) m_hi = hi;
      if (lo_we) m_lo = lo;
    end
    #2;
    chk("R3 rsp_valid", 32'(rsp_valid), 32'(e_rv));
    chk("R7 hit", 32'(hit), 32'(e_hit));
    chk("R7 miss", 32'(miss), 32'(e_miss));
    chk("R8 multi", 32'(multi), 32'(e_multi));
    chk("R9 prot", 32'(prot), 32'(e_prot));
    chk("R10 dfault", 32'(dfault), 32'(e_df));
    chk("R4 cache", 32'(cache), 32'(e_c));
    chk("R5 pa", pa, e_pa);
  end

  task automatic clear_strobes();
    ctrl_we = 0; ctrl_tf = 0; hi_we = 0; lo_we = 0; load = 0; lk_req = 0; lk_write = 0;
  endtask
  task automatic idle();
    @(negedge clk); clear_strobes();
  endtask
  task automatic wctrl(input logic at, ix, sv, tf, input logic [1:0] rc);
    @(negedge clk); clear_strobes();
    ctrl_we = 1; ctrl_at = at; ctrl_ix = ix; ctrl_sv = sv; ctrl_tf = tf; ctrl_rc = rc;
  endtask
  task automatic whi(input logic [31:0] v);
    @(negedge clk); clear_strobes(); hi_we = 1; hi = v;
  endtask
  task automatic wlo(input logic [31:0] v);
    @(negedge clk); clear_strobes(); lo_we = 1; lo = v;
  endtask
  task automatic do_load();
    @(negedge clk); clear_strobes(); load = 1;
  endtask
  task automatic lk(input logic [31:0] va, input logic p, input logic w);
    @(negedge clk); clear_strobes();
    lk_req = 1; lk_va = va; lk_priv = p; lk_write = w;
    @(posedge clk); #3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned pool [4];
    int unsigned base;
    pool[0] = 32'h12345000; pool[1] = 32'h22221000; pool[2] = 32'h33333000; pool[3] = 32'h45678000;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(posedge clk); #3;
    chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
    chk("R1 reset pa", pa, 0);
    lk(32'h12345678, 1, 0);
    chk("R1 bypass after reset pa", pa, 32'h12345678);
    chk("R3 rsp_valid one cycle after req", 32'(rsp_valid), 1);
    idle(); @(posedge clk); #3;
    chk("R3 no req no rsp", 32'(rsp_valid), 0);

    wctrl(1, 0, 0, 0, 2'd0); whi(32'h12345005); wlo(32'h0ABCD06F); do_load();
    lk(32'h12345ABC, 1, 0);
    chk("R2 loaded entry hits", 32'(hit), 1);
    chk("R4 4k pa", pa, 32'h0ABCDABC);
    chk("R4 cacheable", 32'(cache), 1);
    lk(32'h12345ABC, 0, 1);
    chk("R9 user write rw page", 32'(prot), 0);
    chk("R10 dirty page no fault", 32'(dfault), 0);
    whi(32'h12345006);
    lk(32'h12345ABC, 1, 0);
    chk("R6 asid mismatch miss", 32'(miss), 1);
    wctrl(1, 0, 1, 0, 2'd0);
    lk(32'h12345ABC, 1, 0);
    chk("R6 sv privileged hit", 32'(hit), 1);
    lk(32'h12345ABC, 0, 0);
    chk("R6 sv user miss", 32'(miss), 1);

    wctrl(1, 0, 0, 0, 2'd1); whi(32'h22221405); wlo(32'h00345C31); do_load();
    lk(32'h222217FF, 1, 0);
    chk("R5 1k hit", 32'(hit), 1);
    chk("R5 1k pa", pa, 32'h00345FFF);
    lk(32'h22221BFF, 1, 0);
    chk("R5 1k bits 11:10 mismatch", 32'(miss), 1);
    chk("R7 miss pa zero", pa, 0);
    lk(32'h222217FF, 0, 0);
    chk("R9 user on privileged page", 32'(prot), 1);
    lk(32'h222217FF, 1, 1);
    chk("R10 first write fault", 32'(dfault), 1);

    wctrl(1, 0, 0, 0, 2'd2); whi(32'h33333005); wlo(32'h0077700F); do_load();
    lk(32'h33333010, 1, 1);
    chk("R9 write to read-only", 32'(prot), 1);
    lk(32'h33333010, 1, 0);
    chk("R4 read-only read pa", pa, 32'h00777010);

    wctrl(1, 0, 0, 0, 2'd3); whi(32'h12345005); wlo(32'h0100006F); do_load();
    lk(32'h12345ABC, 1, 0);
    chk("R8 multi-hit", 32'(multi), 1);
    chk("R8 no hit on multi", 32'(hit), 0);

    wctrl(1, 1, 0, 0, 2'd2);
    lk(32'h12345ABC, 1, 0);
    chk("R13 hashed index miss", 32'(miss), 1);
    do_load();
    lk(32'h12345ABC, 1, 0);
    chk("R13 hashed index hit", 32'(hit), 1);
    chk("R13 hashed pa", pa, 32'h01000ABC);

    wctrl(1, 0, 0, 1, 2'd0);
    lk(32'h222217FF, 1, 0);
    chk("R11 flushed miss", 32'(miss), 1);
    lk(32'h12345ABC, 1, 0);
    chk("R11 flushed miss 2", 32'(miss), 1);

    wctrl(0, 0, 0, 0, 2'd0);
    lk(32'hDEADBEEF, 0, 1);
    chk("R12 bypass pa", pa, 32'hDEADBEEF);
    chk("R12 bypass flags", {28'd0, hit, miss, prot, dfault}, 0);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); clear_strobes();
      base = pool[$urandom_range(0, 3)];
      if ($urandom_range(0, 15) == 0) begin
        ctrl_we = 1; ctrl_at = ($urandom_range(0, 7) != 0); ctrl_ix = 1'($urandom);
        ctrl_sv = 1'($urandom); ctrl_tf = ($urandom_range(0, 3) == 0); ctrl_rc = 2'($urandom);
      end
      if ($urandom_range(0, 3) == 0) begin
        hi_we = 1; hi = base | ($urandom & 32'h00000C00) | 32'($urandom_range(5, 6));
      end
      if ($urandom_range(0, 3) == 0) begin
        lo_we = 1; lo = ($urandom & 32'h1FFFFC7E) | 32'($urandom_range(0, 7) != 0);
      end
      load     = ($urandom_range(0, 3) == 0);
      lk_req   = 1'($urandom);
      lk_va    = base | ($urandom & 32'h00000FFF);
      lk_priv  = 1'($urandom);
      lk_write = 1'($urandom);
    end
    idle(); idle(); idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule